// File: doc/BRIEF.md
# Output-Stationary Systolic Multiply-Accumulate Grid

This block is the datapath of a small matrix-multiply engine. It is a square grid of multiply-accumulate cells, four rows by four columns by default. Each cell keeps its own partial sum, so the results stay in the cells while the operands move past them. Operands of the left matrix enter on a per-row lane at the left edge and travel rightward one cell per clock. Operands of the right matrix enter on a per-column lane at the top edge and travel downward one cell per clock. A valid flag travels with every operand through the same registers, so operands that were skewed at the edges stay paired as they cross the grid.

A cell adds the product of the two operands it currently sees to its partial sum only when the global enable and both operand valid flags are high. A synchronous clear zeroes every partial sum and leaves the operands in flight untouched. The surrounding logic is responsible for scheduling the inputs, sequencing the phases and capturing results. If it delays row i of the left matrix by i cycles and column j of the right matrix by j cycles, cell (i,j) accumulates the dot product of row i and column j. The whole product is ready on the flat result bus ten cycles after the first operands enter, which is within twelve. The grid has no states of its own. Its only sequencing is the one-cycle hop from one cell to the next.

Top module: `sysmac_grid`

## Requirements
- R1: While rst_n is low, all partial sums, forwarded operands and forwarded valid flags are cleared at the clock edge, so the result bus reads all zeros after reset.
- R2: At a clock edge where en, the cell's A valid and the cell's B valid are all high and clr is low, the cell adds the 16-bit unsigned product of its 8-bit unsigned A and B operands to its 32-bit unsigned partial sum.
- R3: At a clock edge where en is low, or either operand valid seen by a cell is low, and clr is low, that cell's partial sum holds its value, whatever the operand data is.
- R4: A operand and valid move one column to the right per clock edge, and B operand and valid move one row down per clock edge. Cell (i,j) therefore sees the row-i left-edge input j cycles later and the column-j top-edge input i cycles later. Forwarding runs whether en is high or low.
- R5: At a clock edge where clr is high, every partial sum becomes zero, even if a multiply-accumulate would otherwise occur. Operands and valid flags already inside the grid keep moving and are accumulated on later edges.
- R6: The partial sum of cell (i,j) appears on result bits [(i*4+j)*32 +: 32], in row-major order. Edge lanes are packed the same way: row i of A on a_data[i*8 +: 8], and column j of B on b_data[j*8 +: 8].
- R7: When element k of row i of A is driven at input cycle k+i, element k of column j of B at cycle k+j, and en is held high, cell (i,j) holds the dot product of A row i and B column j after edge k+i+j, and all 16 results are final after ten clock edges.
- R8: With all operands at 255, the results (260100 after one product and 520200 after two products without a clear) are exact and never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Global accumulate enable |
| clr | input | 1 | Synchronous clear of all partial sums |
| a_data | input | 32 | Left-edge A operands, one 8-bit lane per row |
| a_vld | input | 4 | Valid flag per row lane |
| b_data | input | 32 | Top-edge B operands, one 8-bit lane per column |
| b_vld | input | 4 | Valid flag per column lane |
| result | output | 512 | Sixteen 32-bit partial sums, row-major |

## Verification
A forwarding register that loses, duplicates or mis-times an operand or its valid flag moves a product term into the wrong cell or the wrong cycle. This shows on the result bus as one or more wrong dot products, no later than ten edges after the first operand enters. A wrong enable or valid gate adds junk data or drops terms in exactly the cells whose lanes were masked, and this can be seen on the first edge where the gate matters. A clear that disturbs the in-flight pipeline, or that loses to accumulation, leaves a partial result different from the sum of the terms that arrive after the clear.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;

    localparam int unsigned SM_DIM_DEF  = 4;
    localparam int unsigned SM_OPW_DEF  = 8;
    localparam int unsigned SM_ACCW_DEF = 32;

    // Low bit of lane idx in a packed bus of w-bit lanes
    function automatic int unsigned lane_lo(input int unsigned idx, input int unsigned w);
        return idx * w;
    endfunction

endpackage

// File: rtl/sysmac_hop.sv
// One forwarding stage: operand and its valid flag, one cycle per hop.
module sysmac_hop #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         vin,
    output logic [W-1:0] dout,
    output logic         vout
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            vout <= 1'b0;
        end else begin
            dout <= din;
            vout <= vin;
        end
    end

    // R4: data and flag advance together, one cycle per hop, independent of enable
    p_hop_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dout == $past(din)) && (vout == $past(vin)));

endmodule

// File: rtl/sysmac_acc.sv
// Per-cell multiply-accumulate with gating and synchronous clear.
module sysmac_acc #(
    parameter int unsigned OPW  = 8,
    parameter int unsigned ACCW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [OPW-1:0]  a_op,
    input  logic            a_v,
    input  logic [OPW-1:0]  b_op,
    input  logic            b_v,
    output logic [ACCW-1:0] psum
);

    localparam int unsigned PRODW = 2 * OPW;

    logic             fire;
    logic [PRODW-1:0] prod;
    logic [ACCW-1:0]  prod_ext;

    always_comb begin
        fire     = en & a_v & b_v;
        prod     = a_op * b_op;
        prod_ext = ACCW'(prod);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum <= '0;
        end else if (clr) begin
            psum <= '0;
        end else if (fire) begin
            psum <= psum + prod_ext;
        end
    end

    // R2: a qualified edge adds exactly the operand product
    p_mac_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_v && b_v && !clr) |=>
            psum == $past(psum) + ACCW'($past(a_op)) * ACCW'($past(b_op)));

    // R3: without all three qualifiers the sum is held
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(en && a_v && b_v) && !clr) |=> $stable(psum));

    // R5: clear wins over accumulation
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (psum == '0));

    // R8: accumulation never wraps below the previous sum
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_v && b_v && !clr) |=> (psum >= $past(psum)));

endmodule

// File: rtl/sysmac_grid.sv
// Output-stationary grid: A flows right, B flows down, sums stay put.
module sysmac_grid
    import sysmac_pkg::*;
#(
    parameter int unsigned ROWS = SM_DIM_DEF,
    parameter int unsigned COLS = SM_DIM_DEF,
    parameter int unsigned OPW  = SM_OPW_DEF,
    parameter int unsigned ACCW = SM_ACCW_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       clr,
    input  logic [ROWS*OPW-1:0]        a_data,
    input  logic [ROWS-1:0]            a_vld,
    input  logic [COLS*OPW-1:0]        b_data,
    input  logic [COLS-1:0]            b_vld,
    output logic [ROWS*COLS*ACCW-1:0]  result
);

    localparam int unsigned CELLS = ROWS * COLS;
    localparam int unsigned RESW  = CELLS * ACCW;

    // Operand seen at the input of each cell
    logic [OPW-1:0] a_net  [ROWS][COLS];
    logic           a_vnet [ROWS][COLS];
    logic [OPW-1:0] b_net  [ROWS][COLS];
    logic           b_vnet [ROWS][COLS];

    genvar r, c;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            for (c = 0; c < COLS; c++) begin : g_col
                // A path: column 0 is the left edge, others take a hop from the left
                if (c == 0) begin : g_a_edge
                    assign a_net[r][c]  = a_data[lane_lo(r, OPW) +: OPW];
                    assign a_vnet[r][c] = a_vld[r];
                end else begin : g_a_hop
                    sysmac_hop #(.W(OPW)) u_a_hop (
                        .clk  (clk),
                        .rst_n(rst_n),
                        .din  (a_net[r][c-1]),
                        .vin  (a_vnet[r][c-1]),
                        .dout (a_net[r][c]),
                        .vout (a_vnet[r][c])
                    );
                end

                // B path: row 0 is the top edge, others take a hop from above
                if (r == 0) begin : g_b_edge
                    assign b_net[r][c]  = b_data[lane_lo(c, OPW) +: OPW];
                    assign b_vnet[r][c] = b_vld[c];
                end else begin : g_b_hop
                    sysmac_hop #(.W(OPW)) u_b_hop (
                        .clk  (clk),
                        .rst_n(rst_n),
                        .din  (b_net[r-1][c]),
                        .vin  (b_vnet[r-1][c]),
                        .dout (b_net[r][c]),
                        .vout (b_vnet[r][c])
                    );
                end

                logic [ACCW-1:0] cell_sum;

                sysmac_acc #(.OPW(OPW), .ACCW(ACCW)) u_acc (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .en   (en),
                    .clr  (clr),
                    .a_op (a_net[r][c]),
                    .a_v  (a_vnet[r][c]),
                    .b_op (b_net[r][c]),
                    .b_v  (b_vnet[r][c]),
                    .psum (cell_sum)
                );

                // R6: row-major placement
                assign result[lane_lo(r * COLS + c, ACCW) +: ACCW] = cell_sum;
            end
        end
    endgenerate

    // R1: first cycle out of reset shows an all-zero result bus
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result == {RESW{1'b0}}));

endmodule

// File: tb/sysmac_grid_bench.sv
`timescale 1ns/1ps
module sysmac_grid_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         clr = 1'b0;
    logic [31:0]  a_data = '0;
    logic [3:0]   a_vld = '0;
    logic [31:0]  b_data = '0;
    logic [3:0]   b_vld = '0;
    logic [511:0] result;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int unsigned ma [N][N];
    int unsigned mb [N][N];
    int unsigned ex [N][N];

    always #2.5 clk = ~clk;

    sysmac_grid u_sysmac_grid (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
        .a_data(a_data), .a_vld(a_vld), .b_data(b_data), .b_vld(b_vld),
        .result(result)
    );

    function automatic logic [31:0] res(input int i, input int j);
        return result[(i*N+j)*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                chk(req, res(i, j), ex[i][j]);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) ex[i][j] = 0;
    endtask

    // Skewed feed of ma x mb, with lane masks, enable level and clear cycle
    task automatic feed(input logic [3:0] amask, input logic [3:0] bmask,
                        input logic en_v, input int clr_at);
        for (int t = 0; t < 10; t++) begin
            for (int i = 0; i < N; i++) begin
                int k = t - i;
                if (amask[i] && k >= 0 && k < N) begin
                    a_data[i*8 +: 8] = 8'(ma[i][k]);
                    a_vld[i] = 1'b1;
                end else begin
                    a_data[i*8 +: 8] = 8'hEE;
                    a_vld[i] = 1'b0;
                end
            end
            for (int j = 0; j < N; j++) begin
                int k = t - j;
                if (bmask[j] && k >= 0 && k < N) begin
                    b_data[j*8 +: 8] = 8'(mb[k][j]);
                    b_vld[j] = 1'b1;
                end else begin
                    b_data[j*8 +: 8] = 8'hDD;
                    b_vld[j] = 1'b0;
                end
            end
            en = en_v;
            clr = (t == clr_at);
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    int k = t - i - j;
                    if (t == clr_at) ex[i][j] = 0;
                    else if (en_v && amask[i] && bmask[j] && k >= 0 && k < N)
                        ex[i][j] += ma[i][k] * mb[k][j];
                end
            tick();
        end
        a_vld = '0; b_vld = '0; clr = 1'b0; en = 1'b1;
        tick();
        tick();
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) ex[i][j] = 0;
        check_all("R1 reset zero");
    endtask

    task automatic test_identity();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = (i == j) ? 1 : 0;
                mb[i][j] = 10 * i + j + 1;
            end
        do_clear();
        feed(4'hF, 4'hF, 1'b1, -1);
        check_all("R7 R6 identity product");
    endtask

    task automatic test_pattern();
        int unsigned s = 32'h1234;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                s = s * 1103515245 + 12345;
                ma[i][j] = (s >> 16) & 8'hFF;
                s = s * 1103515245 + 12345;
                mb[i][j] = (s >> 16) & 8'hFF;
            end
        do_clear();
        feed(4'hF, 4'hF, 1'b1, -1);
        check_all("R7 R2 mixed product");
    endtask

    task automatic test_max();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = 255;
                mb[i][j] = 255;
            end
        do_clear();
        feed(4'hF, 4'hF, 1'b1, -1);
        chk("R8 single max", res(3, 3), 32'd260100);
        feed(4'hF, 4'hF, 1'b1, -1);
        check_all("R8 R2 accumulate twice");
        chk("R8 double max", res(0, 2), 32'd520200);
    endtask

    task automatic test_enable_low();
        // ex holds the prior results; en low must leave them untouched
        feed(4'hF, 4'hF, 1'b0, -1);
        check_all("R3 enable low holds");
    endtask

    task automatic test_mask();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = i + j + 2;
                mb[i][j] = 3 * i + j + 1;
            end
        do_clear();
        feed(4'b1011, 4'b1101, 1'b1, -1);
        check_all("R3 valid mask");
        chk("R3 masked row", res(2, 0), 32'd0);
    endtask

    task automatic test_clear_midflight();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ma[i][j] = i * 4 + j + 1;
                mb[i][j] = 16 - (i * 4 + j);
            end
        do_clear();
        chk("R5 clear zero", res(1, 1), 32'd0);
        feed(4'hF, 4'hF, 1'b1, 4);
        check_all("R5 clear keeps in-flight operands");
    endtask

    task automatic test_hop_timing();
        do_clear();
        en = 1'b1;
        a_vld = '0; b_vld = '0;
        a_data[2*8 +: 8] = 8'd3; a_vld[2] = 1'b1;
        tick();
        a_vld = '0;
        b_data[3*8 +: 8] = 8'd5; b_vld[3] = 1'b1;
        tick();
        b_vld = '0;
        tick();
        chk("R4 not yet at cell(2,3)", res(2, 3), 32'd0);
        tick();
        chk("R4 arrival at cell(2,3)", res(2, 3), 32'd15);
        chk("R6 bit placement", result[(2*4+3)*32 +: 32], 32'd15);
        chk("R4 neighbour (2,2) untouched", res(2, 2), 32'd0);
        chk("R4 neighbour (1,3) untouched", res(1, 3), 32'd0);
    endtask

    initial begin
        test_reset();
        test_identity();
        test_pattern();
        test_max();
        test_enable_low();
        test_mask();
        test_clear_midflight();
        test_hop_timing();
        test_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule